// File: doc/BRIEF.md
# Predicated Per-Lane Variable Shift Unit

This block shifts every lane of a packed 128-bit vector by an amount held in the matching lane of a second vector. It supports arithmetic right, logical right and logical left shifts. The lane width can be set to 8, 16, 32 or 64 bits for each operation. The shift count is the whole unsigned lane value and is never folded modulo the lane width. When the count is too large, a right-arithmetic shift fills the lane with copies of the sign bit, and the two logical shifts clear the lane.

A byte-granular predicate enables lanes one by one. A disabled lane passes the first operand's lane through unchanged. A reverse flag swaps the operand roles, so that the second operand is shifted and the first supplies the counts; predicated-off lanes still return the first operand. The result is registered, one operation can be accepted every cycle, and the result appears one clock after the input strobe.

Top module: `lane_shift_unit`

## Requirements
- R1: With `opSel` = 2'b00 and a lane count below the lane width, the lane result is the shifted value moved right arithmetically by the count, so the sign bit is copied into the vacated upper bits.
- R2: With `opSel` = 2'b00 and a lane count equal to or above the lane width, every bit of the lane result equals the shifted value's sign bit.
- R3: With `opSel` = 2'b01 the lane result is the value moved right logically with zero fill, and a count equal to or above the lane width gives zero.
- R4: With `opSel` = 2'b11 the lane result is the value moved left with zero fill, and a count equal to or above the lane width gives zero.
- R5: The count is the full unsigned lane value and is not taken modulo the lane width. For example, a count of 9 in a byte lane, or of 2^32+1 in a 64-bit lane, counts as an oversized shift.
- R6: `elemSize` encodes the lane width: 2'b00 is 8 bits, 2'b01 is 16, 2'b10 is 32 and 2'b11 is 64. Lane i occupies bits [i*W +: W], and there are 128/W lanes.
- R7: With `revMode` = 1 the shifted value comes from `opB` and the count comes from `opA`. With `revMode` = 0 the value comes from `opA` and the count from `opB`.
- R8: Lane i is enabled by predicate bit i*W/8, which is the lowest bit of its byte group. A disabled lane outputs the `opA` lane unchanged in both operand orders.
- R9: `opSel` = 2'b10 is reserved. It returns `opA` unchanged in every lane, and `outValid` is still asserted.
- R10: `outValid` equals `inValid` delayed by one clock. `result` is loaded only in a cycle with `inValid` high and holds its value otherwise.
- R11: A synchronous reset clears both `outValid` and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operation strobe |
| opA | input | 128 | First operand: value, or counts in reverse mode; also the merge source |
| opB | input | 128 | Second operand: counts, or value in reverse mode |
| predBits | input | 16 | Per-byte lane predicate |
| elemSize | input | 2 | Lane width select |
| opSel | input | 2 | Shift kind select |
| revMode | input | 1 | Swap the roles of value and count |
| outValid | output | 1 | Result valid, one clock after `inValid` |
| result | output | 128 | Registered result vector |

## Verification
The assertions assume that every input carries a known value whenever it is sampled. They also assume that reset is held for at least one clock before the first operation, so that the hold and pass-through properties compare against a defined register. The bench drives every input to a defined value from time zero and keeps reset asserted for several clocks. Stimulus is applied only on falling edges, so operands are stable at each rising edge where the checker samples them.

// File: rtl/lane_shift_pkg.sv
package lane_shift_pkg;

  typedef enum logic [1:0] {
    SH_ASR = 2'b00,
    SH_LSR = 2'b01,
    SH_RSV = 2'b10,
    SH_LSL = 2'b11
  } shift_op_e;

  typedef enum logic [1:0] {
    SZ_8  = 2'b00,
    SZ_16 = 2'b01,
    SZ_32 = 2'b10,
    SZ_64 = 2'b11
  } elem_size_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      capture;
    logic      swap;
    logic      passThru;
    shift_op_e kind;
  } shift_ctrl_t;

endpackage

// File: rtl/lane_shift_ctrl.sv
module lane_shift_ctrl
  import lane_shift_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [1:0]  opSel,
  input  logic        revMode,
  output shift_ctrl_t ctrl,
  output logic        outValid
);

  shift_op_e opKind;

  always_comb begin
    opKind = shift_op_e'(opSel);
    ctrl.capture  = inValid;
    ctrl.swap     = revMode;
    ctrl.passThru = (opKind == SH_RSV);
    ctrl.kind     = opKind;
  end

  // R10, R11: valid pipeline stage
  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

endmodule

// File: rtl/lane_shift_datapath.sv
module lane_shift_datapath
  import lane_shift_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic                 clk,
  input  logic                 rst,
  input  shift_ctrl_t          ctrl,
  input  logic [VEC_W-1:0]     opA,
  input  logic [VEC_W-1:0]     opB,
  input  logic [VEC_W/8-1:0]   predBits,
  input  logic [1:0]           elemSize,
  output logic [VEC_W-1:0]     result
);

  localparam int NUM_SIZES = 4;

  logic [NUM_SIZES-1:0][VEC_W-1:0] sizeRes;
  logic [VEC_W-1:0]                nextRes;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int EW = 8 << s;
    localparam int SW = 3 + s;
    localparam int NL = VEC_W / EW;
    localparam logic [SW-1:0] MAXSH = SW'(EW - 1);

    for (genvar l = 0; l < NL; l++) begin : g_lane
      logic [EW-1:0] laneA, laneB, val, amt, shifted;
      logic [SW-1:0] shAmt;
      logic          oversize, enabled;

      assign laneA    = opA[l*EW +: EW];
      assign laneB    = opB[l*EW +: EW];
      assign val      = ctrl.swap ? laneB : laneA;   // R7
      assign amt      = ctrl.swap ? laneA : laneB;
      assign shAmt    = amt[SW-1:0];
      assign oversize = |amt[EW-1:SW];              // R5: full count
      assign enabled  = predBits[l*EW/8];           // R8

      always_comb begin
        unique case (ctrl.kind)
          SH_ASR:  shifted = EW'($signed(val) >>> (oversize ? MAXSH : shAmt));
          SH_LSR:  shifted = oversize ? '0 : (val >> shAmt);
          SH_LSL:  shifted = oversize ? '0 : (val << shAmt);
          default: shifted = laneA;
        endcase
      end

      assign sizeRes[s][l*EW +: EW] =
        (ctrl.passThru || !enabled) ? laneA : shifted;
    end
  end

  always_comb begin
    nextRes = sizeRes[elemSize];
  end

  // R10, R11: result register
  always_ff @(posedge clk) begin
    if (rst)               result <= '0;
    else if (ctrl.capture) result <= nextRes;
  end

endmodule

// File: rtl/lane_shift_unit.sv
module lane_shift_unit
  import lane_shift_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [VEC_W-1:0]   opA,
  input  logic [VEC_W-1:0]   opB,
  input  logic [VEC_W/8-1:0] predBits,
  input  logic [1:0]         elemSize,
  input  logic [1:0]         opSel,
  input  logic               revMode,
  output logic               outValid,
  output logic [VEC_W-1:0]   result
);

  shift_ctrl_t ctrl;

  lane_shift_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .opSel    (opSel),
    .revMode  (revMode),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  lane_shift_datapath #(.VEC_W(VEC_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .opA      (opA),
    .opB      (opB),
    .predBits (predBits),
    .elemSize (elemSize),
    .result   (result)
  );

endmodule

// File: rtl/lane_shift_checker.sv
module lane_shift_checker #(
  parameter int VEC_W = 128
) (
  input logic               clk,
  input logic               rst,
  input logic               inValid,
  input logic [VEC_W-1:0]   opA,
  input logic [VEC_W/8-1:0] predBits,
  input logic [1:0]         opSel,
  input logic               outValid,
  input logic [VEC_W-1:0]   result
);

  p_valid_follows_r10: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  p_valid_drops_r10: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  p_hold_result_r10: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(result));

  p_reserved_pass_r9: assert property (@(posedge clk) disable iff (rst)
    (inValid && opSel == 2'b10) |=> (result == $past(opA) && outValid));

  p_all_masked_r8: assert property (@(posedge clk) disable iff (rst)
    (inValid && predBits == '0) |=> (result == $past(opA)));

  p_reset_clears_r11: assert property (@(posedge clk)
    rst |=> (!outValid && result == '0));

endmodule

bind lane_shift_unit lane_shift_checker #(.VEC_W(VEC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .opA      (opA),
  .predBits (predBits),
  .opSel    (opSel),
  .outValid (outValid),
  .result   (result)
);

// File: tb/lane_shift_unit_tb.sv
module lane_shift_unit_tb;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [127:0] opA = '0, opB = '0;
  logic [15:0]  predBits = '0;
  logic [1:0]   elemSize = '0, opSel = '0;
  logic         revMode = 1'b0;
  logic         outValid;
  logic [127:0] result;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lane_shift_unit u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .predBits(predBits), .elemSize(elemSize), .opSel(opSel),
    .revMode(revMode), .outValid(outValid), .result(result)
  );

  function automatic logic [127:0] refModel(
    logic [127:0] a, logic [127:0] b, logic [15:0] pred,
    logic [1:0] es, logic [1:0] op, logic rev);
    int ew;
    logic [127:0] r;
    logic [63:0] mask, va, vb, v, c, res;
    logic signed [63:0] sv;
    ew = 8 << es;
    r = a;
    if (op == 2'b10) return a;
    mask = (ew == 64) ? '1 : ((64'd1 << ew) - 64'd1);
    for (int l = 0; l < 128 / ew; l++) begin
      va = 64'(a >> (l * ew)) & mask;
      vb = 64'(b >> (l * ew)) & mask;
      v = rev ? vb : va;
      c = rev ? va : vb;
      if (!pred[l * ew / 8]) continue;
      if (op == 2'b00) begin
        if (v[ew-1]) sv = $signed(v | ~mask);
        else         sv = $signed(v);
        if (c >= 64'(ew)) res = v[ew-1] ? mask : '0;
        else              res = 64'(sv >>> c) & mask;
      end else if (op == 2'b01) begin
        res = (c >= 64'(ew)) ? '0 : (v >> c);
      end else begin
        res = (c >= 64'(ew)) ? '0 : ((v << c) & mask);
      end
      r = (r & ~({64'd0, mask} << (l * ew))) | ({64'd0, res} << (l * ew));
    end
    return r;
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one operation at a falling edge, check one clock later
  task automatic runOp(string tag, logic [127:0] a, logic [127:0] b,
                       logic [15:0] p, logic [1:0] es, logic [1:0] op, logic rv);
    @(negedge clk);
    opA = a; opB = b; predBits = p; elemSize = es; opSel = op; revMode = rv;
    inValid = 1'b1;
    @(negedge clk);
    check({tag, " valid R10"}, {127'd0, outValid}, 128'd1);
    check(tag, result, refModel(a, b, p, es, op, rv));
    inValid = 1'b0;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // per-lane counts spread around the lane width
  function automatic logic [127:0] nearCounts(logic [1:0] es);
    int ew;
    logic [127:0] r;
    ew = 8 << es;
    r = '0;
    for (int l = 0; l < 128 / ew; l++)
      r = r | (128'($urandom_range(ew + 3, 0)) << (l * ew));
    return r;
  endfunction

  task automatic finish();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish();
    end
  end

  initial begin
    logic [127:0] held;
    repeat (4) @(negedge clk);
    // R11: reset state
    check("R11 reset result", result, '0);
    check("R11 reset valid", {127'd0, outValid}, '0);
    rst = 1'b0;

    // R1 R2 R5: byte ASR, counts 0..15 across lanes on negative values
    runOp("R1 R2 R5 asr byte", {16{8'h96}},
          128'h0f0e0d0c0b0a09080706050403020100, 16'hffff, 2'b00, 2'b00, 1'b0);
    // R2: positive values saturate to zero
    runOp("R2 asr positive", {16{8'h5a}}, {16{8'h20}}, 16'hffff, 2'b00, 2'b00, 1'b0);
    // R3 R5: halfword LSR with counts 15,16,17,255
    runOp("R3 R5 lsr half", {8{16'hf00f}},
          {16'd15, 16'd16, 16'd17, 16'd255, 16'd1, 16'd0, 16'd8, 16'd4},
          16'hffff, 2'b01, 2'b01, 1'b0);
    // R4 R5: 64-bit LSL, count 2^32+1 must not act as 1
    runOp("R4 R5 lsl dword", {2{64'h0000_0000_0000_0041}},
          {64'h0000_0001_0000_0001, 64'd63}, 16'hffff, 2'b11, 2'b11, 1'b0);
    runOp("R4 lsl word 32", {4{32'h1}}, {32'd32, 32'd31, 32'd33, 32'd0},
          16'hffff, 2'b10, 2'b11, 1'b0);
    // R7: reverse, counts in opA
    runOp("R7 reverse lsl", {16{8'd3}}, {16{8'h81}}, 16'hffff, 2'b00, 2'b11, 1'b1);
    // R8: alternate lanes disabled, reverse keeps opA
    runOp("R8 predicate rev", {16{8'd2}}, {16{8'hf0}}, 16'h5555, 2'b00, 2'b01, 1'b1);
    // R8: only non-lowest bits of each 32-bit group set -> all lanes off
    runOp("R8 upper pred bits", rnd128(), nearCounts(2'b10), 16'heeee, 2'b10, 2'b00, 1'b0);
    // R9: reserved select
    runOp("R9 reserved", rnd128(), rnd128(), 16'hffff, 2'b01, 2'b10, 1'b1);

    // R6 R7: sweep of all sizes, kinds and orders
    for (int es = 0; es < 4; es++)
      for (int op = 0; op < 4; op++)
        for (int rv = 0; rv < 2; rv++)
          for (int n = 0; n < 24; n++) begin
            logic [127:0] cnt, val;
            cnt = (n % 6 == 5) ? rnd128() : nearCounts(2'(es));
            val = rnd128();
            runOp("R6 R7 sweep", rv ? cnt : val, rv ? val : cnt,
                  (n % 3 == 0) ? 16'($urandom) : 16'hffff,
                  2'(es), 2'(op), 1'(rv));
          end

    // R10: inputs change with strobe low, result holds
    held = result;
    @(negedge clk);
    opA = rnd128(); opB = rnd128(); opSel = 2'b11;
    @(negedge clk);
    check("R10 hold result", result, held);
    check("R10 valid low", {127'd0, outValid}, '0);

    // R11: reset in mid-stream
    runOp("R1 pre-reset", rnd128(), nearCounts(2'b01), 16'hffff, 2'b01, 2'b00, 1'b0);
    @(negedge clk);
    rst = 1'b1; inValid = 1'b1;
    @(negedge clk);
    check("R11 mid reset result", result, '0);
    check("R11 mid reset valid", {127'd0, outValid}, '0);
    rst = 1'b0; inValid = 1'b0;

    done = 1'b1;
    finish();
  end

endmodule